// File: doc/BRIEF.md
# MSI Snooping Coherence Line Controller

This block holds the coherence state of one cache line in one private cache that shares a snooping bus with other caches. It follows the three-state MSI protocol: Invalid (no usable copy), Shared (clean copy that others may also hold) and Modified (the only copy, dirty). Two kinds of events move the line. Requests from the local processor arrive with a hit flag from the tag lookup. Bus transactions issued by other caches are snooped.

Local requests may need a bus transaction: a read for a shared copy (BusRd) or a read-for-ownership (BusRdX). Snooped requests from other caches can force a Modified copy to be handed to the requester and written back to memory, or can invalidate a copy. Every snooped transaction carries the requester's identifier. The controller drops transactions that carry its own identifier, so the local path and the remote path stay apart. Tag storage, data storage, arbitration and memory timing sit outside this block.

All outputs are registered. A request or snoop seen at one rising edge shows its effect on the outputs right after that edge.

Top module: `msi_line_ctrl`

## Requirements
- R1: After reset, `line_state` is Invalid (encoding I=0, S=1, M=2), and `bus_req_valid`, `wb_req` and `data_give` are low. Every output reflects the inputs sampled at the previous rising edge.
- R2: A local read that misses moves the line to Shared and raises `bus_req_valid` with `bus_req_rdx`=0 (BusRd). A read misses when the line is Invalid or `cpu_hit` is low.
- R3: A local write that misses moves the line to Modified and raises `bus_req_valid` with `bus_req_rdx`=1 (BusRdX). A write misses when the line is Invalid or `cpu_hit` is low.
- R4: A local write hit on a Shared line issues BusRdX (`bus_req_rdx`=1) and moves the line to Modified.
- R5: These requests issue no bus request and leave the state unchanged: a local read hit on Shared, and a local read or write hit on Modified.
- R6: A remote BusRd (`snoop_rdx`=0) that hits a Modified line raises both `wb_req` and `data_give` for one cycle and moves the line to Shared.
- R7: A remote BusRdX (`snoop_rdx`=1) that hits a Modified line raises both `wb_req` (write back to memory) and `data_give` (supply data to the requester) and moves the line to Invalid.
- R8: A remote BusRdX moves a Shared line to Invalid without a writeback. A remote BusRd leaves a Shared line Shared.
- R9: An Invalid line ignores remote BusRd and BusRdX. It stays Invalid and raises nothing.
- R10: A snooped transaction whose `snoop_src` equals the instance's `CACHE_ID` is ignored.
- R11: When a remote snoop and a local request arrive at the same edge, the snoop is applied first. The local request is then evaluated against the resulting state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Local processor access to this line |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_hit | input | 1 | Tag lookup hit for the access |
| snoop_valid | input | 1 | A bus transaction is being snooped |
| snoop_rdx | input | 1 | 1 = BusRdX, 0 = BusRd |
| snoop_src | input | ID_W | Identifier of the issuing cache |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_rdx | output | 1 | 1 = BusRdX, 0 = BusRd |
| wb_req | output | 1 | Write the line back to memory |
| data_give | output | 1 | Supply the line's data to the requester |
| line_state | output | 2 | Current coherence state |

## Verification
Three controllers share a modelled bus. Each local request is followed by a broadcast of any bus request it raises, so the requester sees its own transaction, which must be ignored, and the other caches see it as remote traffic. A directed sequence walks a line through a read miss, an upgrade, a shared read that forces a flush to Shared, and a write miss that forces a flush to Invalid, which separates the BusRd and BusRdX responses in every state. A fixed-seed random phase mixes reads, writes and hit flags that disagree with the state. Injected foreign snoops that coincide with local requests show whether the snoop is ordered before the local request.

// File: rtl/msi_pkg.sv
package msi_pkg;

    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_MOD = 2'd2
    } ln_state_e;

    typedef struct packed {
        ln_state_e st;
        logic      req;
        logic      rdx;
        logic      wb;
        logic      give;
    } ln_regs_t;

    localparam ln_regs_t LN_REGS_RST = '{st: LN_INV, req: 1'b0, rdx: 1'b0, wb: 1'b0, give: 1'b0};

endpackage

// File: rtl/msi_snoop_gate.sv
module msi_snoop_gate #(
    parameter int ID_W     = 2,
    parameter int CACHE_ID = 0
) (
    input  logic            snoop_valid,
    input  logic [ID_W-1:0] snoop_src,
    output logic            remote
);
    localparam logic [ID_W-1:0] SELF = ID_W'(CACHE_ID);

    always_comb begin
        remote = snoop_valid && (snoop_src != SELF);
    end
endmodule

// File: rtl/msi_remote_step.sv
module msi_remote_step
    import msi_pkg::*;
(
    input  ln_state_e cur,
    input  logic      remote,
    input  logic      rdx,
    output ln_state_e nxt,
    output logic      flush
);
    always_comb begin
        nxt   = cur;
        flush = 1'b0;
        if (remote) begin
            unique case (cur)
                LN_MOD: begin
                    flush = 1'b1;
                    nxt   = rdx ? LN_INV : LN_SHR;
                end
                LN_SHR: begin
                    nxt = rdx ? LN_INV : LN_SHR;
                end
                default: begin
                    nxt = LN_INV;
                end
            endcase
        end
    end
endmodule

// File: rtl/msi_local_step.sv
module msi_local_step
    import msi_pkg::*;
(
    input  ln_state_e cur,
    input  logic      valid,
    input  logic      write,
    input  logic      hit,
    output ln_state_e nxt,
    output logic      req,
    output logic      rdx
);
    ln_state_e eff;

    always_comb begin
        eff = hit ? cur : LN_INV;
        nxt = cur;
        req = 1'b0;
        rdx = 1'b0;
        if (valid) begin
            if (write) begin
                nxt = LN_MOD;
                if (eff != LN_MOD) begin
                    req = 1'b1;
                    rdx = 1'b1;
                end
            end else if (eff == LN_INV) begin
                nxt = LN_SHR;
                req = 1'b1;
            end
        end
    end
endmodule

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl
    import msi_pkg::*;
#(
    parameter int ID_W     = 2,
    parameter int CACHE_ID = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cpu_req_valid,
    input  logic            cpu_req_write,
    input  logic            cpu_hit,
    input  logic            snoop_valid,
    input  logic            snoop_rdx,
    input  logic [ID_W-1:0] snoop_src,
    output logic            bus_req_valid,
    output logic            bus_req_rdx,
    output logic            wb_req,
    output logic            data_give,
    output logic [1:0]      line_state
);
    ln_regs_t  regs_d, regs_q;
    logic      remote;
    ln_state_e mid_st, fin_st;
    logic      flush_hit, loc_req, loc_rdx;

    msi_snoop_gate #(.ID_W(ID_W), .CACHE_ID(CACHE_ID)) u_gate (
        .snoop_valid (snoop_valid),
        .snoop_src   (snoop_src),
        .remote      (remote)
    );

    msi_remote_step u_remote (
        .cur    (regs_q.st),
        .remote (remote),
        .rdx    (snoop_rdx),
        .nxt    (mid_st),
        .flush  (flush_hit)
    );

    msi_local_step u_local (
        .cur   (mid_st),
        .valid (cpu_req_valid),
        .write (cpu_req_write),
        .hit   (cpu_hit),
        .nxt   (fin_st),
        .req   (loc_req),
        .rdx   (loc_rdx)
    );

    always_comb begin
        regs_d      = regs_q;
        regs_d.st   = fin_st;
        regs_d.req  = loc_req;
        regs_d.rdx  = loc_rdx;
        regs_d.wb   = flush_hit;
        regs_d.give = flush_hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= LN_REGS_RST;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign bus_req_valid = regs_q.req;
    assign bus_req_rdx   = regs_q.rdx;
    assign wb_req        = regs_q.wb;
    assign data_give     = regs_q.give;
    assign line_state    = regs_q.st;
endmodule

// File: rtl/msi_line_chk.sv
module msi_line_chk #(
    parameter int ID_W     = 2,
    parameter int CACHE_ID = 0
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cpu_req_valid,
    input logic            cpu_req_write,
    input logic            cpu_hit,
    input logic            snoop_valid,
    input logic            snoop_rdx,
    input logic [ID_W-1:0] snoop_src,
    input logic            bus_req_valid,
    input logic            bus_req_rdx,
    input logic            wb_req,
    input logic            data_give,
    input logic [1:0]      line_state
);
    localparam logic [ID_W-1:0] SELF = ID_W'(CACHE_ID);

    logic foreign;
    assign foreign = snoop_valid && (snoop_src != SELF);

    p_write_owns_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_valid && cpu_req_write) |=> (line_state == 2'd2));

    p_req_from_cpu_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid |-> $past(cpu_req_valid));

    p_mod_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state == 2'd2 && cpu_req_valid && cpu_hit && !foreign)
        |=> (!bus_req_valid && line_state == 2'd2));

    p_wb_from_mod_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> ($past(line_state) == 2'd2 && $past(foreign)));

    p_wb_with_give_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req || data_give) |-> (wb_req && data_give));

    p_inv_ignores_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state == 2'd0 && snoop_valid && !cpu_req_valid)
        |=> (line_state == 2'd0 && !wb_req));

    p_own_snoop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_valid && snoop_src == SELF && !cpu_req_valid)
        |=> ($stable(line_state) && !wb_req && !bus_req_valid));
endmodule

bind msi_line_ctrl msi_line_chk #(.ID_W(ID_W), .CACHE_ID(CACHE_ID)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req_valid (cpu_req_valid),
    .cpu_req_write (cpu_req_write),
    .cpu_hit       (cpu_hit),
    .snoop_valid   (snoop_valid),
    .snoop_rdx     (snoop_rdx),
    .snoop_src     (snoop_src),
    .bus_req_valid (bus_req_valid),
    .bus_req_rdx   (bus_req_rdx),
    .wb_req        (wb_req),
    .data_give     (data_give),
    .line_state    (line_state)
);

// File: tb/msi_line_ctrl_tb.sv
module msi_line_ctrl_tb;
    localparam int N    = 3;
    localparam int ID_W = 2;
    localparam logic [1:0] SI = 2'd0, SS = 2'd1, SM = 2'd2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] cpu_v = '0, cpu_w = '0, cpu_h = '0;
    logic sn_v = 1'b0, sn_rdx = 1'b0;
    logic [ID_W-1:0] sn_src = '0;
    logic [N-1:0] o_req, o_rdx, o_wb, o_give;
    logic [1:0] o_st [N];

    logic [1:0] mst [N];
    int n_chk = 0;
    int n_bad = 0;
    logic last_req;
    logic last_rdx;

    always #10 clk = ~clk;

    for (genvar i = 0; i < N; i++) begin : g_c
        msi_line_ctrl #(.ID_W(ID_W), .CACHE_ID(i)) u_dut (
            .clk           (clk),
            .rst_n         (rst_n),
            .cpu_req_valid (cpu_v[i]),
            .cpu_req_write (cpu_w[i]),
            .cpu_hit       (cpu_h[i]),
            .snoop_valid   (sn_v),
            .snoop_rdx     (sn_rdx),
            .snoop_src     (sn_src),
            .bus_req_valid (o_req[i]),
            .bus_req_rdx   (o_rdx[i]),
            .wb_req        (o_wb[i]),
            .data_give     (o_give[i]),
            .line_state    (o_st[i])
        );
    end

    function automatic logic [1:0] rem_next(logic [1:0] s, logic rdx);
        if (s == SI) return SI;
        return rdx ? SI : SS;
    endfunction

    function automatic logic [3:0] loc_next(logic [1:0] s, logic w, logic h);
        logic [1:0] e;
        e = h ? s : SI;
        if (w) return (e == SM) ? {SM, 2'b00} : {SM, 2'b11};
        if (e == SI) return {SS, 2'b10};
        return {s, 2'b00};
    endfunction

    function automatic string loc_tag(logic [1:0] s, logic w, logic h);
        if (!h || s == SI) return w ? "R3" : "R2";
        if (s == SS && w) return "R4";
        return "R5";
    endfunction

    task automatic check(int c, string tag, logic [1:0] es, logic er, logic erx, logic ewb);
        n_chk++;
        if (o_st[c] !== es || o_req[c] !== er || (er && o_rdx[c] !== erx) ||
            o_wb[c] !== ewb || o_give[c] !== ewb) begin
            n_bad++;
            $display("FAIL %s cache%0d: got st=%0d req=%b rdx=%b wb=%b give=%b exp st=%0d req=%b rdx=%b wb=%b give=%b",
                     tag, c, o_st[c], o_req[c], o_rdx[c], o_wb[c], o_give[c], es, er, erx, ewb, ewb);
        end
    endtask

    // One edge: optional snoop broadcast to all, optional local request on cache cp.
    task automatic cycle(logic sv, logic srdx, int src, int cp, logic w, logic h);
        logic [1:0] s1;
        logic [3:0] lr;
        logic wb;
        logic remote;
        string tag;
        sn_v = sv; sn_rdx = srdx; sn_src = ID_W'(src);
        cpu_v = '0; cpu_w = '0; cpu_h = '0;
        if (cp >= 0) begin
            cpu_v[cp] = 1'b1; cpu_w[cp] = w; cpu_h[cp] = h;
        end
        @(posedge clk);
        @(negedge clk);
        sn_v = 1'b0; cpu_v = '0;
        last_req = 1'b0; last_rdx = 1'b0;
        for (int i = 0; i < N; i++) begin
            remote = sv && (src != i);
            s1 = remote ? rem_next(mst[i], srdx) : mst[i];
            wb = remote && mst[i] == SM;
            if (sv && src == i) tag = "R10";
            else if (remote && mst[i] == SI) tag = "R9";
            else if (remote && mst[i] == SM) tag = srdx ? "R7" : "R6";
            else if (remote) tag = "R8";
            else tag = "idle";
            lr = {s1, 2'b00};
            if (i == cp) begin
                lr = loc_next(s1, w, h);
                tag = (remote && mst[i] != s1) ? "R11" : loc_tag(s1, w, h);
                last_req = lr[1]; last_rdx = lr[0];
            end
            check(i, tag, lr[3:2], lr[1], lr[0], wb);
            mst[i] = lr[3:2];
        end
    endtask

    task automatic local_op(int p, logic w, logic h);
        cycle(1'b0, 1'b0, 0, p, w, h);
        if (last_req) cycle(1'b1, last_rdx, p, -1, 1'b0, 1'b0);
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int seed;
        seed = 1234;
        void'($urandom(seed));
        for (int i = 0; i < N; i++) mst[i] = SI;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < N; i++) check(i, "R1", SI, 1'b0, 1'b0, 1'b0);

        // Directed walk through every state and transition
        local_op(0, 1'b0, 1'b0);   // R2 read miss on cache0
        local_op(1, 1'b0, 1'b0);   // R2 read miss on cache1
        local_op(1, 1'b0, 1'b1);   // R5 read hit on S
        local_op(1, 1'b1, 1'b1);   // R4 upgrade, cache0 S->I (R8)
        local_op(1, 1'b0, 1'b1);   // R5 read hit on M
        local_op(1, 1'b1, 1'b1);   // R5 write hit on M
        local_op(0, 1'b0, 1'b0);   // R6 cache1 flushes to S
        local_op(2, 1'b1, 1'b0);   // R3 write miss, R8 others invalidate
        local_op(0, 1'b1, 1'b0);   // R7 cache2 flushes to I
        cycle(1'b1, 1'b0, 3, -1, 1'b0, 1'b0);        // R6 foreign BusRd: cache0 M->S
        cycle(1'b1, 1'b0, 3, -1, 1'b0, 1'b0);        // R8 shared stays shared, R9
        local_op(0, 1'b1, 1'b1);                     // R4 back to M
        cycle(1'b1, 1'b1, 3, 0, 1'b0, 1'b1);         // R11 snoop first, then read miss
        cycle(1'b1, 1'b0, 0, 0, 1'b1, 1'b1);         // R10 own snoop with local write
        cycle(1'b1, 1'b1, 3, 0, 1'b1, 1'b1);         // R11 BusRdX on M then write

        // Constrained random phase
        for (int k = 0; k < 400; k++) begin
            int p;
            logic w, h;
            p = int'($urandom % N);
            w = 1'($urandom);
            h = ($urandom % 4 == 0) ? 1'($urandom) : (mst[p] != SI);
            if ($urandom % 6 == 0)
                cycle(1'b1, 1'($urandom), 3, p, w, h);
            else
                local_op(p, w, h);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule